// File: doc/BRIEF.md
# Indirect Internal-Register Access Bridge

This bridge lets a host that only sees a handful of 32-bit mailbox registers reach a 16-bit internal register space. The host first writes a control word. Its low sixteen bits carry the halfword address of the target register, and the bits above them carry a tag that the bridge does not decode. For a write, the host also loads a data word. It then writes a command code. The bridge latches the operation and runs exactly one access on a request/acknowledge internal register bus. When the access finishes, the bridge posts the outcome in a result word that the host polls.

The result word holds three fields. A ready flag shows that the last accepted command has finished. A two-bit response code says how it finished. A 16-bit data field carries the read data. The data field is only meaningful when ready is set and the code is OK; in every other outcome it carries 0xFFFF. If the internal bus never acknowledges, a timeout ends the access. The length of that timeout is set by the parameter `TMO_CYCLES`, which defaults to 16 cycles.

Top module: `hreg_bridge`

## Requirements
- R1: After a synchronous reset the result word reads 0x0000FFFF and `ib_req` is low.
- R2: The mailbox is selected by `host_sel`: 0 is the control word, 1 is the write-data word, 2 is the command, and 3 is the result word. The bus address is bits 15:0 of the control word, and bits 31:16 of that word have no effect on the access.
- R3: Writing command code 1 starts an internal write. In the cycle after the command write, `ib_req` is high, `ib_we` is 1, and `ib_wdata` equals bits 15:0 of the write-data word.
- R4: Writing command code 2 starts an internal read. When the bus acknowledges without error, the result word becomes ready=1 (bit 18), code=1 (bits 17:16) and data=`ib_rdata` (bits 15:0).
- R5: An accepted command clears ready in the next cycle, and ready stays clear while the access is pending. Ready and `ib_req` are never high together.
- R6: While `ib_req` is high without acknowledge, the address, direction and write data on the bus stay stable. Changes to the mailbox do not alter them. `ib_req` drops in the cycle after an acknowledge.
- R7: If no acknowledge arrives during `TMO_CYCLES` cycles of request, the access ends with ready=1, code=0 and data 0xFFFF. An acknowledge in the last of those cycles still counts as a normal completion.
- R8: An acknowledge together with `ib_err` gives ready=1, code=3 and data 0xFFFF.
- R9: A command code other than 1 or 2 is rejected in the next cycle with ready=1, code=2 and data 0xFFFF, and no bus request is made.
- R10: A completed write sets ready=1 and code=1, with data 0xFFFF.
- R11: A command written while an access is pending is ignored.
- R12: The control word reads back as written in full. The write-data word reads back zero-extended, and reading the command register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host mailbox write strobe |
| host_sel | input | 2 | Mailbox select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Readback of the selected mailbox |
| ib_req | output | 1 | Internal bus request, held until acknowledge or timeout |
| ib_we | output | 1 | Internal bus direction, 1 = write |
| ib_addr | output | 16 | Internal halfword address |
| ib_wdata | output | 16 | Internal write data |
| ib_ack | input | 1 | Internal bus acknowledge |
| ib_err | input | 1 | Error flag, sampled with acknowledge |
| ib_rdata | input | 16 | Internal read data, sampled with acknowledge |

## Verification
The bench runs reads, writes, erroneous responses, missing responses and illegal command codes. The result word must tell all five outcomes apart through its code and data fields.

Acknowledges are placed at three points:
- in the first cycle of the request;
- after a delay, which shows that the bus lines hold still while the request waits;
- in the very last cycle of the timeout window, which separates a late completion from a timeout.

Two further tests cover the mailbox itself:
- A control word with a nonzero upper tag shows that the tag is not decoded.
- Mailbox and command writes made during a pending access show that the access is isolated from later host activity.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

    localparam int HW_DATA_W = 16;
    localparam int HW_ADDR_W = 16;
    localparam int HOST_W    = 32;
    localparam int CODE_W    = 2;
    localparam int PAD_W     = HOST_W - HW_DATA_W - CODE_W - 1;

    typedef enum logic [CODE_W-1:0] {
        RC_NORESP  = 2'd0,
        RC_OK      = 2'd1,
        RC_REJECT  = 2'd2,
        RC_BUSERR  = 2'd3
    } rsp_code_e;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_WDATA  = 2'd1,
        SEL_CMD    = 2'd2,
        SEL_RESULT = 2'd3
    } mbox_sel_e;

    localparam logic [HOST_W-1:0]    OP_WRITE = 32'd1;
    localparam logic [HOST_W-1:0]    OP_READ  = 32'd2;
    localparam logic [HW_DATA_W-1:0] FILL     = '1;

    typedef struct packed {
        logic                 ready;
        rsp_code_e            code;
        logic [HW_DATA_W-1:0] data;
    } result_t;

    typedef struct packed {
        logic                 we;
        logic [HW_ADDR_W-1:0] addr;
        logic [HW_DATA_W-1:0] wdata;
    } op_t;

    function automatic logic [HOST_W-1:0] pack_result(result_t r);
        return {{PAD_W{1'b0}}, r.ready, r.code, r.data};
    endfunction

    function automatic logic known_op(logic [HOST_W-1:0] c);
        return (c == OP_WRITE) || (c == OP_READ);
    endfunction

endpackage

// File: rtl/hreg_mailbox.sv
module hreg_mailbox
    import hreg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_we,
    input  logic [1:0]           host_sel,
    input  logic [HOST_W-1:0]    host_wdata,
    output logic [HOST_W-1:0]    host_rdata,
    input  result_t              result,
    output logic                 cmd_go,
    output logic [HOST_W-1:0]    cmd_code,
    output logic [HW_ADDR_W-1:0] cur_addr,
    output logic [HW_DATA_W-1:0] cur_wdata
);

    mbox_sel_e             sel;
    logic [HOST_W-1:0]     ctrl_q;
    logic [HW_DATA_W-1:0]  wdata_q;

    assign sel = mbox_sel_e'(host_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            wdata_q <= '0;
        end else if (host_we) begin
            if (sel == SEL_CTRL)  ctrl_q  <= host_wdata;
            if (sel == SEL_WDATA) wdata_q <= host_wdata[HW_DATA_W-1:0];
        end
    end

    // Only the halfword address field is decoded; the tag above it is kept for readback.
    assign cur_addr  = ctrl_q[HW_ADDR_W-1:0];
    assign cur_wdata = wdata_q;
    assign cmd_go    = host_we && (sel == SEL_CMD);
    assign cmd_code  = host_wdata;

    always_comb begin
        case (sel)
            SEL_CTRL:   host_rdata = ctrl_q;
            SEL_WDATA:  host_rdata = {{(HOST_W-HW_DATA_W){1'b0}}, wdata_q};
            SEL_CMD:    host_rdata = '0;
            default:    host_rdata = pack_result(result);
        endcase
    end

endmodule

// File: rtl/hreg_engine.sv
module hreg_engine
    import hreg_pkg::*;
#(
    parameter int TMO_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_go,
    input  logic [HOST_W-1:0]    cmd_code,
    input  logic [HW_ADDR_W-1:0] cur_addr,
    input  logic [HW_DATA_W-1:0] cur_wdata,
    output logic                 ib_req,
    output logic                 ib_we,
    output logic [HW_ADDR_W-1:0] ib_addr,
    output logic [HW_DATA_W-1:0] ib_wdata,
    input  logic                 ib_ack,
    input  logic                 ib_err,
    input  logic [HW_DATA_W-1:0] ib_rdata,
    output result_t              result
);

    localparam int              CNT_W = $clog2(TMO_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYCLES - 1);

    typedef enum logic {ENG_IDLE, ENG_WAIT} eng_state_e;

    eng_state_e       state;
    op_t              op;
    logic [CNT_W-1:0] cnt;
    result_t          res;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENG_IDLE;
            op    <= '0;
            cnt   <= '0;
            res   <= '{ready: 1'b0, code: RC_NORESP, data: FILL};
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (cmd_go) begin
                        if (known_op(cmd_code)) begin
                            op        <= '{we: (cmd_code == OP_WRITE), addr: cur_addr, wdata: cur_wdata};
                            cnt       <= '0;
                            res.ready <= 1'b0;
                            state     <= ENG_WAIT;
                        end else begin
                            res <= '{ready: 1'b1, code: RC_REJECT, data: FILL};
                        end
                    end
                end
                default: begin
                    if (ib_ack) begin
                        state <= ENG_IDLE;
                        if (ib_err)
                            res <= '{ready: 1'b1, code: RC_BUSERR, data: FILL};
                        else
                            res <= '{ready: 1'b1, code: RC_OK, data: (op.we ? FILL : ib_rdata)};
                    end else if (cnt == LAST) begin
                        state <= ENG_IDLE;
                        res   <= '{ready: 1'b1, code: RC_NORESP, data: FILL};
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign ib_req   = (state == ENG_WAIT);
    assign ib_we    = op.we;
    assign ib_addr  = op.addr;
    assign ib_wdata = op.wdata;
    assign result   = res;

    p_clear_on_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        (!ib_req && cmd_go && known_op(cmd_code)) |=> (!result.ready && ib_req));

    p_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(ib_req && result.ready));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ib_req && !ib_ack) |=> ($stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata)));

    p_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (ib_req && ib_ack) |=> !ib_req);

    p_ok_r4: assert property (@(posedge clk) disable iff (rst)
        (ib_req && ib_ack && !ib_err) |=> (result.ready && result.code == RC_OK));

    p_err_r8: assert property (@(posedge clk) disable iff (rst)
        (ib_req && ib_ack && ib_err) |=> (result.code == RC_BUSERR && result.data == FILL));

    p_reject_r9: assert property (@(posedge clk) disable iff (rst)
        (!ib_req && cmd_go && !known_op(cmd_code)) |=> (result.ready && result.code == RC_REJECT && !ib_req));

    p_window_r7: assert property (@(posedge clk) disable iff (rst)
        ib_req |-> (cnt <= LAST));

endmodule

// File: rtl/hreg_bridge.sv
module hreg_bridge
    import hreg_pkg::*;
#(
    parameter int TMO_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [1:0]  host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        ib_req,
    output logic        ib_we,
    output logic [15:0] ib_addr,
    output logic [15:0] ib_wdata,
    input  logic        ib_ack,
    input  logic        ib_err,
    input  logic [15:0] ib_rdata
);

    result_t              result;
    logic                 cmd_go;
    logic [HOST_W-1:0]    cmd_code;
    logic [HW_ADDR_W-1:0] cur_addr;
    logic [HW_DATA_W-1:0] cur_wdata;

    hreg_mailbox u_mbox (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .result     (result),
        .cmd_go     (cmd_go),
        .cmd_code   (cmd_code),
        .cur_addr   (cur_addr),
        .cur_wdata  (cur_wdata)
    );

    hreg_engine #(.TMO_CYCLES(TMO_CYCLES)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .cmd_go    (cmd_go),
        .cmd_code  (cmd_code),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .ib_req    (ib_req),
        .ib_we     (ib_we),
        .ib_addr   (ib_addr),
        .ib_wdata  (ib_wdata),
        .ib_ack    (ib_ack),
        .ib_err    (ib_err),
        .ib_rdata  (ib_rdata),
        .result    (result)
    );

endmodule

// File: tb/hreg_bridge_tb_top.sv
`timescale 1ns/1ps
module hreg_bridge_tb_top;

    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        ib_req, ib_we;
    logic [15:0] ib_addr, ib_wdata;
    logic        ib_ack = 1'b0;
    logic        ib_err = 1'b0;
    logic [15:0] ib_rdata = '0;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    hreg_bridge #(.TMO_CYCLES(TMO)) dut_i (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
        .ib_ack(ib_ack), .ib_err(ib_err), .ib_rdata(ib_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = val;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] sel, output logic [31:0] val);
        host_sel = sel;
        #0.5;
        val = host_rdata;
    endtask

    task automatic ack_once(input logic err, input logic [15:0] data);
        ib_ack = 1'b1; ib_err = err; ib_rdata = data;
        @(negedge clk);
        ib_ack = 1'b0; ib_err = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        host_read(2'd3, v);
        chk("R1 reset result", v, 32'h0000FFFF);
        chk("R1 reset req", {31'd0, ib_req}, 32'd0);
    endtask

    task automatic t_read_ok();
        logic [31:0] v;
        host_write(2'd0, (32'h1234 >> 1) + 32'h30000);
        host_write(2'd2, 32'd2);
        chk("R2 addr", {16'd0, ib_addr}, 32'h091A);
        chk("R4 dir read", {31'd0, ib_we}, 32'd0);
        host_read(2'd3, v);
        chk("R5 ready cleared", {31'd0, v[18]}, 32'd0);
        ack_once(1'b0, 16'hBEEF);
        host_read(2'd3, v);
        chk("R4 read result", v, 32'h0005BEEF);
        chk("R6 req drop", {31'd0, ib_req}, 32'd0);
    endtask

    task automatic t_write_ok();
        logic [31:0] v;
        host_write(2'd0, 32'h0003_0010);
        host_write(2'd1, 32'hDEAD_A5A5);
        host_write(2'd2, 32'd1);
        chk("R3 req", {31'd0, ib_req}, 32'd1);
        chk("R3 dir", {31'd0, ib_we}, 32'd1);
        chk("R3 wdata", {16'd0, ib_wdata}, 32'hA5A5);
        chk("R3 addr", {16'd0, ib_addr}, 32'h0010);
        repeat (3) @(negedge clk);
        chk("R6 held addr", {16'd0, ib_addr}, 32'h0010);
        chk("R6 held req", {31'd0, ib_req}, 32'd1);
        ack_once(1'b0, 16'h0000);
        host_read(2'd3, v);
        chk("R10 write result", v, 32'h0005FFFF);
        host_read(2'd1, v);
        chk("R12 wdata readback", v, 32'h0000A5A5);
        host_read(2'd0, v);
        chk("R12 ctrl readback", v, 32'h0003_0010);
        host_read(2'd2, v);
        chk("R12 cmd readback", v, 32'd0);
    endtask

    task automatic t_error();
        logic [31:0] v;
        host_write(2'd2, 32'd2);
        ack_once(1'b1, 16'h1234);
        host_read(2'd3, v);
        chk("R8 error result", v, 32'h0007FFFF);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        host_write(2'd2, 32'd2);
        for (int i = 0; i < TMO - 1; i++) @(negedge clk);
        chk("R7 req before window end", {31'd0, ib_req}, 32'd1);
        host_read(2'd3, v);
        chk("R7 not ready yet", {31'd0, v[18]}, 32'd0);
        @(negedge clk);
        host_read(2'd3, v);
        chk("R7 timeout result", v, 32'h0004FFFF);
        chk("R7 req dropped", {31'd0, ib_req}, 32'd0);
    endtask

    task automatic t_late_ack();
        logic [31:0] v;
        host_write(2'd2, 32'd2);
        for (int i = 0; i < TMO - 1; i++) @(negedge clk);
        ack_once(1'b0, 16'h7E57);
        host_read(2'd3, v);
        chk("R7 ack in last cycle", v, 32'h00057E57);
    endtask

    task automatic t_reject();
        logic [31:0] v;
        host_write(2'd2, 32'd3);
        host_read(2'd3, v);
        chk("R9 reject result", v, 32'h0006FFFF);
        chk("R9 no req", {31'd0, ib_req}, 32'd0);
        host_write(2'd2, 32'h0000_0102);
        host_read(2'd3, v);
        chk("R9 reject wide code", v, 32'h0006FFFF);
    endtask

    task automatic t_tag_ignored();
        host_write(2'd0, 32'hFFFF_0042);
        host_write(2'd2, 32'd2);
        chk("R2 tag ignored", {16'd0, ib_addr}, 32'h0042);
        ack_once(1'b0, 16'h0001);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        host_write(2'd0, 32'h0003_0123);
        host_write(2'd2, 32'd2);
        host_write(2'd0, 32'h0003_0456);
        host_write(2'd2, 32'd1);
        chk("R11 dir unchanged", {31'd0, ib_we}, 32'd0);
        chk("R6 addr isolated", {16'd0, ib_addr}, 32'h0123);
        ack_once(1'b0, 16'h1111);
        host_read(2'd3, v);
        chk("R11 original read result", v, 32'h00051111);
        @(negedge clk);
        chk("R11 no second access", {31'd0, ib_req}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_ok();
        t_write_ok();
        t_error();
        t_timeout();
        t_late_ack();
        t_reject();
        t_tag_ignored();
        t_busy_ignore();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule